// File: doc/BRIEF.md
# Signed-Amount Bidirectional Shifter

This block shifts one data word by a signed distance. The sign of the amount selects the direction: a positive amount shifts left and a negative amount shifts right. The magnitude gives the number of bit positions. The block has two modes.

In arithmetic mode the data is fixed-point. It is either the full 40-bit word, with the 8 guard bits above bit 31 included, or only its low 32 bits when guard handling is off. Arithmetic right shifts copy the sign bit of the active width into the vacated positions.

In logical mode only a 16-bit field is shifted. Vacated positions fill with zeros in either direction.

Each request is presented with a one-cycle strobe. The result appears in registers on the following cycle, together with a carry. The carry holds the last bit pushed out of the active width. A condition flag reports the same shifted-out bit for downstream conditional logic. Instruction decode lies outside this block: the caller supplies the mode, the guard select and the amount directly.

Top module: `dsp_shifter`

## Requirements
- R1: A high `inValid` sampled at a rising clock edge makes `outValid` high for the cycle that follows, with the new `result`, `carryOut` and `dcFlag`. A low `inValid` makes `outValid` low in the next cycle.
- R2: In arithmetic mode (`logicMode`=0) with `guardOn`=1, a positive amount n shifts the 40-bit `operand` left by n with zero fill. `carryOut` is operand bit 40-n.
- R3: In arithmetic mode with `guardOn`=1, a negative amount -n shifts the 40-bit operand right by n. Bit 39 is copied into the vacated positions, and `carryOut` is operand bit n-1.
- R4: In arithmetic mode with `guardOn`=0, only `operand[31:0]` is shifted, using the same rules with bit 31 as the sign. `operand[39:32]` is ignored. Result bits [39:32] are copies of result bit 31.
- R5: In logical mode (`logicMode`=1), the field `operand[31:16]` is shifted with zero fill in both directions, and the result field is placed back in bits [31:16]. Result bits [15:0] and [39:32] are zero. `carryOut` is field bit 16-n for a left shift by n, and field bit n-1 for a right shift by n.
- R6: `shiftAmt` is a 7-bit two's-complement value. In arithmetic mode it is clamped to the range -32..+32, and in logical mode to -16..+16.
- R7: An amount of zero gives `carryOut`=0. In arithmetic mode it leaves the active data unchanged. In logical mode it leaves the field unchanged.
- R8: Whenever `outValid` is high, `dcFlag` equals `carryOut`.
- R9: After reset, `result`, `carryOut`, `dcFlag` and `outValid` are zero. While `inValid` stays low, `result`, `carryOut` and `dcFlag` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| operand | input | 40 | Data to shift |
| shiftAmt | input | 7 | Signed shift amount, two's complement |
| logicMode | input | 1 | 1 selects the logical 16-bit shift, 0 the arithmetic shift |
| guardOn | input | 1 | Arithmetic width: 1 selects 40 bits, 0 selects 32 bits |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 40 | Shifted data |
| carryOut | output | 1 | Last bit shifted out |
| dcFlag | output | 1 | Condition flag, equal to the shifted-out bit |

## Verification
The bench builds the shifter with its default parameters: a 40-bit word, a 32-bit narrow width, a 16-bit logical field at bit 16 and a 7-bit amount. With a 7-bit amount, values from -64 to +63 can be driven. These lie beyond both the ±32 and the ±16 limits, so clamping can be reached in both modes. A sweep of every amount from -40 to +40 in each mode covers the limit shifts that empty the active width entirely, and the single-bit shifts at the other extreme.

// File: rtl/dsp_shift_pkg.sv
package dsp_shift_pkg;

  // Magnitude field wide enough for the largest legal distance (32).
  localparam int unsigned MAG_W = 6;

  // Strobes and decoded amount handed from control to datapath.
  typedef struct packed {
    logic             load;     // capture a new result this cycle
    logic             isLogic;  // logical field shift
    logic             wide;     // arithmetic width includes guard bits
    logic             dirLeft;  // 1 = left, 0 = right
    logic [MAG_W-1:0] mag;      // clamped distance
  } shift_ctrl_t;

endpackage

// File: rtl/dsp_shift_ctrl.sv
module dsp_shift_ctrl
  import dsp_shift_pkg::*;
#(
  parameter int unsigned AMT_W     = 7,
  parameter int unsigned ARITH_MAX = 32,
  parameter int unsigned LOGIC_MAX = 16
) (
  input  logic             inValid,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             logicMode,
  input  logic             guardOn,
  output shift_ctrl_t      ctrl
);

  localparam int AMT_HI = (1 << (AMT_W - 1)) - 1;
  localparam int AMT_LO = -(1 << (AMT_W - 1));

  // Decide whether each limit is reachable from the amount width at all.
  localparam bit ARITH_CLAMP = (int'(ARITH_MAX) < AMT_HI) || (-int'(ARITH_MAX) > AMT_LO);
  localparam bit LOGIC_CLAMP = (int'(LOGIC_MAX) < AMT_HI) || (-int'(LOGIC_MAX) > AMT_LO);

  logic signed [AMT_W-1:0] amtSigned;
  logic signed [AMT_W:0]   limitPos;
  logic signed [AMT_W:0]   limitNeg;
  logic signed [AMT_W:0]   amtExt;
  logic signed [AMT_W:0]   amtClamped;
  logic        [AMT_W:0]   amtAbs;
  logic                    clampOn;

  assign amtSigned = $signed(shiftAmt);
  assign amtExt    = (AMT_W + 1)'(amtSigned);

  generate
    if (ARITH_CLAMP || LOGIC_CLAMP) begin : g_clamp
      assign clampOn = logicMode ? LOGIC_CLAMP : ARITH_CLAMP;
    end else begin : g_noclamp
      assign clampOn = 1'b0;
    end
  endgenerate

  always_comb begin
    limitPos = logicMode ? (AMT_W + 1)'(LOGIC_MAX) : (AMT_W + 1)'(ARITH_MAX);
    limitNeg = -limitPos;
    if (clampOn && (amtExt > limitPos)) begin
      amtClamped = limitPos;
    end else if (clampOn && (amtExt < limitNeg)) begin
      amtClamped = limitNeg;
    end else begin
      amtClamped = amtExt;
    end
    amtAbs = amtClamped[AMT_W] ? (AMT_W + 1)'(-amtClamped) : (AMT_W + 1)'(amtClamped);
  end

  always_comb begin
    ctrl         = '0;
    ctrl.load    = inValid;
    ctrl.isLogic = logicMode;
    ctrl.wide    = guardOn;
    ctrl.dirLeft = !amtClamped[AMT_W];
    ctrl.mag     = MAG_W'(amtAbs);
  end

endmodule

// File: rtl/dsp_shift_datapath.sv
module dsp_shift_datapath
  import dsp_shift_pkg::*;
#(
  parameter int unsigned DATA_W   = 40,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned FIELD_LO = 16,
  parameter int unsigned FIELD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  shift_ctrl_t       ctrl,
  input  logic [DATA_W-1:0] operand,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              dcFlag
);

  localparam int unsigned GUARD_W  = DATA_W - NARROW_W;
  localparam int unsigned FIELD_HI = FIELD_LO + FIELD_W - 1;
  localparam int unsigned UPPER_W  = DATA_W - FIELD_HI - 1;

  // ---------------- arithmetic path ----------------
  logic        [DATA_W:0]   arLeftSrc;
  logic        [DATA_W:0]   arLeftT;
  logic signed [DATA_W:0]   arRightSrc;
  logic signed [DATA_W:0]   arRightT;
  logic        [DATA_W-1:0] arLeftRes;
  logic        [DATA_W-1:0] arRightRes;
  logic                     arLeftCy;
  logic                     arRightCy;

  always_comb begin
    if (ctrl.wide) begin
      arLeftSrc  = {1'b0, operand};
      arRightSrc = {operand, 1'b0};
    end else begin
      arLeftSrc  = {{(GUARD_W + 1){1'b0}}, operand[NARROW_W-1:0]};
      arRightSrc = {{GUARD_W{operand[NARROW_W-1]}}, operand[NARROW_W-1:0], 1'b0};
    end
  end

  assign arLeftT  = arLeftSrc << ctrl.mag;
  assign arRightT = arRightSrc >>> ctrl.mag;

  always_comb begin
    if (ctrl.wide) begin
      arLeftRes = arLeftT[DATA_W-1:0];
      arLeftCy  = arLeftT[DATA_W];
    end else begin
      arLeftRes = {{GUARD_W{arLeftT[NARROW_W-1]}}, arLeftT[NARROW_W-1:0]};
      arLeftCy  = arLeftT[NARROW_W];
    end
    // Sign copies already fill the guard bits in narrow mode.
    arRightRes = arRightT[DATA_W:1];
    arRightCy  = arRightT[0];
  end

  // ---------------- logical path ----------------
  logic [FIELD_W-1:0] fieldIn;
  logic [FIELD_W:0]   lgLeftT;
  logic [FIELD_W:0]   lgRightT;
  logic [FIELD_W-1:0] lgField;
  logic               lgCy;
  logic [DATA_W-1:0]  lgRes;

  assign fieldIn  = operand[FIELD_HI:FIELD_LO];
  assign lgLeftT  = {1'b0, fieldIn} << ctrl.mag;
  assign lgRightT = {fieldIn, 1'b0} >> ctrl.mag;

  always_comb begin
    if (ctrl.dirLeft) begin
      lgField = lgLeftT[FIELD_W-1:0];
      lgCy    = lgLeftT[FIELD_W];
    end else begin
      lgField = lgRightT[FIELD_W:1];
      lgCy    = lgRightT[0];
    end
  end

  generate
    if (UPPER_W > 0 && FIELD_LO > 0) begin : g_both
      assign lgRes = {{UPPER_W{1'b0}}, lgField, {FIELD_LO{1'b0}}};
    end else if (UPPER_W > 0) begin : g_upper
      assign lgRes = {{UPPER_W{1'b0}}, lgField};
    end else if (FIELD_LO > 0) begin : g_lower
      assign lgRes = {lgField, {FIELD_LO{1'b0}}};
    end else begin : g_none
      assign lgRes = lgField;
    end
  endgenerate

  // ---------------- selection and registers ----------------
  logic [DATA_W-1:0] nextRes;
  logic              nextCy;

  always_comb begin
    if (ctrl.isLogic) begin
      nextRes = lgRes;
      nextCy  = lgCy;
    end else if (ctrl.dirLeft) begin
      nextRes = arLeftRes;
      nextCy  = arLeftCy;
    end else begin
      nextRes = arRightRes;
      nextCy  = arRightCy;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      carryOut <= 1'b0;
      dcFlag   <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        result   <= nextRes;
        carryOut <= nextCy;
        dcFlag   <= nextCy;
      end
    end
  end

endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter
  import dsp_shift_pkg::*;
#(
  parameter int unsigned DATA_W    = 40,
  parameter int unsigned NARROW_W  = 32,
  parameter int unsigned FIELD_LO  = 16,
  parameter int unsigned FIELD_W   = 16,
  parameter int unsigned AMT_W     = 7,
  parameter int unsigned ARITH_MAX = 32,
  parameter int unsigned LOGIC_MAX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              logicMode,
  input  logic              guardOn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              dcFlag
);

  shift_ctrl_t ctrl;

  dsp_shift_ctrl #(
    .AMT_W    (AMT_W),
    .ARITH_MAX(ARITH_MAX),
    .LOGIC_MAX(LOGIC_MAX)
  ) u_ctrl (
    .inValid  (inValid),
    .shiftAmt (shiftAmt),
    .logicMode(logicMode),
    .guardOn  (guardOn),
    .ctrl     (ctrl)
  );

  dsp_shift_datapath #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .FIELD_LO(FIELD_LO),
    .FIELD_W (FIELD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .operand (operand),
    .outValid(outValid),
    .result  (result),
    .carryOut(carryOut),
    .dcFlag  (dcFlag)
  );

endmodule

// File: rtl/dsp_shifter_checker.sv
module dsp_shifter_checker #(
  parameter int unsigned DATA_W   = 40,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned FIELD_LO = 16,
  parameter int unsigned FIELD_W  = 16,
  parameter int unsigned AMT_W    = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] operand,
  input logic [AMT_W-1:0]  shiftAmt,
  input logic              logicMode,
  input logic              guardOn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              dcFlag
);

  localparam int unsigned GUARD_W  = DATA_W - NARROW_W;
  localparam int unsigned FIELD_HI = FIELD_LO + FIELD_W - 1;

  // R1: strobe produces a valid result one cycle later
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R4: narrow arithmetic result has sign-copied guard bits
  a_r4_guard_sign: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !logicMode && !guardOn) |=>
      (result[DATA_W-1:NARROW_W] == {GUARD_W{result[NARROW_W-1]}}));

  // R5: logical result is zero outside the field
  a_r5_field_only: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && logicMode) |=>
      ((result & ~({{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << FIELD_LO)) == '0));

  // R7: zero amount gives zero carry and unchanged wide data
  a_r7_zero_amount: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && shiftAmt == '0) |=> !carryOut);
  a_r7_zero_wide: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && shiftAmt == '0 && !logicMode && guardOn) |=>
      (result == $past(operand)));
  a_r7_zero_field: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && shiftAmt == '0 && logicMode) |=>
      (result[FIELD_HI:FIELD_LO] == $past(operand[FIELD_HI:FIELD_LO])));

  // R8: condition flag tracks the carry
  a_r8_dc_match: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (dcFlag == carryOut));

  // R9: outputs hold while no request arrives
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(carryOut) && $stable(dcFlag)));

endmodule

bind dsp_shifter dsp_shifter_checker #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W),
  .FIELD_LO(FIELD_LO),
  .FIELD_W (FIELD_W),
  .AMT_W   (AMT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .operand  (operand),
  .shiftAmt (shiftAmt),
  .logicMode(logicMode),
  .guardOn  (guardOn),
  .outValid (outValid),
  .result   (result),
  .carryOut (carryOut),
  .dcFlag   (dcFlag)
);

// File: tb/tb_dsp_shifter.sv
module tb_dsp_shifter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [39:0] operand = '0;
  logic [6:0]  shiftAmt = '0;
  logic        logicMode = 1'b0;
  logic        guardOn = 1'b1;
  logic        outValid;
  logic [39:0] result;
  logic        carryOut;
  logic        dcFlag;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsp_shifter dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .shiftAmt(shiftAmt), .logicMode(logicMode), .guardOn(guardOn),
    .outValid(outValid), .result(result), .carryOut(carryOut), .dcFlag(dcFlag)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bit-by-bit reference built from the requirements; returns {carry, result}.
  function automatic logic [40:0] refShift(input logic [39:0] op, input int amt, input bit lg, input bit gd);
    int lim = lg ? 16 : 32;
    int a = (amt > lim) ? lim : ((amt < -lim) ? -lim : amt);
    int n = (a < 0) ? -a : a;
    logic c = 1'b0;
    if (lg) begin
      logic [15:0] f = op[31:16];
      for (int i = 0; i < n; i++) begin
        if (a > 0) begin c = f[15]; f = {f[14:0], 1'b0}; end
        else       begin c = f[0];  f = {1'b0, f[15:1]}; end
      end
      return {c, 8'h00, f, 16'h0000};
    end else begin
      int w = gd ? 40 : 32;
      logic [39:0] v = gd ? op : {{8{op[31]}}, op[31:0]};
      for (int i = 0; i < n; i++) begin
        if (a > 0) begin c = v[w-1]; v = v << 1; end
        else       begin c = v[0];   v = {v[39], v[39:1]}; end
      end
      if (!gd) v = {{8{v[31]}}, v[31:0]};
      return {c, v};
    end
  endfunction

  // Issue one request and check the registered outcome a cycle later.
  task automatic doShift(input logic [39:0] op, input int amt, input bit lg, input bit gd, input string req);
    logic [40:0] exp;
    exp = refShift(op, amt, lg, gd);
    @(negedge clk);
    operand = op; shiftAmt = amt[6:0]; logicMode = lg; guardOn = gd; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, {req, " R1 valid"}, 64'(outValid), 64'd1);
    check(result === exp[39:0], {req, " result"}, 64'(result), 64'(exp[39:0]));
    check(carryOut === exp[40], {req, " carry"}, 64'(carryOut), 64'(exp[40]));
    check(dcFlag === exp[40], {req, " R8 dc"}, 64'(dcFlag), 64'(exp[40]));
  endtask

  task automatic testReset();
    check(outValid === 1'b0, "R9 reset valid", 64'(outValid), 0);
    check(result === '0, "R9 reset result", 64'(result), 0);
    check(carryOut === 1'b0 && dcFlag === 1'b0, "R9 reset flags", 64'({carryOut, dcFlag}), 0);
  endtask

  task automatic testWideLeft();   // R2
    doShift(40'hA5_1234_5678, 5, 0, 1, "R2 left5");
    doShift(40'h81_0000_0001, 1, 0, 1, "R2 left1");
    doShift(40'hFF_FFFF_FFFF, 32, 0, 1, "R2 left32");
    check(result === 40'hFF_0000_0000, "R2 left32 value", 64'(result), 64'hFF_0000_0000);
  endtask

  task automatic testWideRight();  // R3
    doShift(40'h80_0000_00F0, -7, 0, 1, "R3 neg right7");
    check(result[39:33] === 7'h7F, "R3 sign fill", 64'(result[39:33]), 64'h7F);
    doShift(40'h40_0000_8000, -32, 0, 1, "R3 pos right32");
    doShift(40'h00_0000_0003, -1, 0, 1, "R3 right1 carry");
    check(carryOut === 1'b1, "R3 carry bit0", 64'(carryOut), 1);
  endtask

  task automatic testNarrow();     // R4
    doShift(40'h5A_4000_0001, 1, 0, 0, "R4 left into sign");
    check(result === 40'hFF_8000_0002, "R4 guard copies", 64'(result), 64'hFF_8000_0002);
    doShift(40'h00_8000_0000, -4, 0, 0, "R4 right sign31");
    check(result === 40'hFF_F800_0000, "R4 narrow sign fill", 64'(result), 64'hFF_F800_0000);
    doShift(40'hC3_0000_0001, 32, 0, 0, "R4 left32 narrow");
  endtask

  task automatic testLogic();      // R5
    doShift(40'hFF_8421_FFFF, 3, 1, 1, "R5 left3");
    doShift(40'hFF_8421_FFFF, -3, 1, 0, "R5 right3");
    check(result[31:29] === 3'b000, "R5 zero fill", 64'(result[31:29]), 0);
    doShift(40'h00_8001_0000, 16, 1, 1, "R5 left16");
    doShift(40'h00_8001_0000, -16, 1, 1, "R5 right16");
    check(carryOut === 1'b1, "R5 right16 carry", 64'(carryOut), 1);
  endtask

  task automatic testClamp();      // R6
    doShift(40'h12_3456_789B, 63, 0, 1, "R6 arith +63");
    doShift(40'h92_3456_789B, -64, 0, 1, "R6 arith -64");
    doShift(40'h00_ABCD_0000, 20, 1, 1, "R6 logic +20");
    check(result === '0, "R6 logic clamp empties field", 64'(result), 0);
    doShift(40'h00_ABCD_0000, -64, 1, 1, "R6 logic -64");
  endtask

  task automatic testZero();       // R7
    doShift(40'hDE_ADBE_EF01, 0, 0, 1, "R7 zero wide");
    check(result === 40'hDE_ADBE_EF01 && carryOut === 1'b0, "R7 unchanged", 64'(result), 64'hDE_ADBE_EF01);
    doShift(40'h12_F00F_3456, 0, 1, 1, "R7 zero logic");
  endtask

  task automatic testHold();       // R9
    logic [39:0] kept;
    logic keptCy;
    doShift(40'h80_0000_0001, -1, 0, 1, "R9 prime");
    kept = result; keptCy = carryOut;
    @(negedge clk);
    operand = 40'h0F_0F0F_0F0F; shiftAmt = 7'd3; logicMode = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R9 idle valid", 64'(outValid), 0);
    check(result === kept, "R9 hold result", 64'(result), 64'(kept));
    check(carryOut === keptCy && dcFlag === keptCy, "R9 hold flags", 64'({carryOut, dcFlag}), 64'({keptCy, keptCy}));
  endtask

  task automatic testSweep();      // R2 R3 R4 R5 R6 sweep
    logic [39:0] pat = 40'hC9_5A3C_E817;
    for (int m = 0; m < 3; m++) begin
      for (int a = -40; a <= 40; a++) begin
        pat = {pat[38:0], pat[39] ^ pat[37] ^ pat[20] ^ pat[1]};
        doShift(pat, a, m == 2, m == 0, "R6 sweep");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testWideLeft();
    testWideRight();
    testNarrow();
    testLogic();
    testClamp();
    testZero();
    testHold();
    testSweep();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule